// File: doc/BRIEF.md
# Binary32 Input Subnormal Flush Stage

This stage sits in front of a single-precision floating-point datapath and conditions its two operands before any arithmetic sees them. When the flush-inputs mode bit is set, every operand that the current operation actually consumes is checked. An operand with an all-zero exponent and a non-zero fraction is replaced by a zero of the same sign, and an input-subnormal exception bit is raised in a sticky seven-bit flag word. This bit is separate from the underflow bit, and this stage never sets underflow.

The operation class tells the stage which operands matter. Two-operand work, comparisons included, has both operands checked independently. One-operand work has only the first operand checked. Sign-only operations such as absolute value and negate bypass the stage entirely: no flush, no flag, and no special treatment of NaNs. Results are registered with one cycle of latency. The flag word accumulates until a synchronous clear or reset.

Top module: `fdn_flush_stage`

## Requirements
- R1: An operand is subnormal exactly when bits 30:23 are all zero and bits 22:0 are not all zero. The operands and `valid_out` appear on the outputs on the clock edge after `valid_in` is sampled high (one cycle of latency).
- R2: A flushed operand is driven out as its input ANDed with 0x80000000, so a negative subnormal becomes 0x80000000 and a positive one becomes 0x00000000.
- R3: While `ftz_in` is 0, both operands pass to the outputs unchanged and no flag is raised, whatever their values.
- R4: Each cycle in which at least one operand is flushed sets flag bit 6 (weight 64). The other flag positions are bit 0 invalid, bit 2 divide-by-zero, bit 3 overflow, bit 4 underflow and bit 5 inexact, with bit 1 unused. This stage never sets any of them, so they read 0.
- R5: The flag word is sticky. It keeps its bits until a cycle with `flag_clr` high clears it. A flush in that same cycle is still recorded, so set wins over clear.
- R6: `op_class` 2 (sign-only) and the unused code 3 bypass the stage. Both operands, including NaNs and subnormals, pass unchanged and nothing is flagged.
- R7: `op_class` 0 (two-operand) checks and flushes `op_a` and `op_b` independently. `op_class` 1 (one-operand) checks only `op_a`, and `op_b` passes unchanged.
- R8: Zeros, infinities, NaNs and normal values are never flushed and never raise the flag.
- R9: Synchronous active-low reset drives `out_a`, `out_b`, `valid_out` and `flags` to 0.
- R10: A cycle with `valid_in` low raises no flag and leaves `out_a` and `out_b` at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| op_class | input | 2 | 0 two-operand, 1 one-operand, 2 sign-only, 3 treated as sign-only |
| ftz_in | input | 1 | Flush-inputs mode enable |
| valid_in | input | 1 | Operands and class are valid this cycle |
| flag_clr | input | 1 | Synchronous clear of the sticky flag word |
| out_a | output | 32 | Conditioned first operand |
| out_b | output | 32 | Conditioned second operand |
| valid_out | output | 1 | Outputs hold a new operation |
| flags | output | 7 | Sticky exception flags, bit 6 input-subnormal |

## Verification
The bench targets the edges of the subnormal range: fraction 1, all-ones fraction, the smallest normal 0x00800000, and both signed zeros. A design with a loose exponent or fraction test would flush a normal or a zero, or miss an extreme subnormal. It also aims at the operation-class decode, sending a subnormal in `op_b` under the one-operand class and subnormals or NaNs under the sign-only class. A wrong decode shows up as a spurious zero or flag there. A clear issued in the same cycle as a flush checks that the event survives, and idle cycles check that nothing is captured or flagged without `valid_in`.

// File: rtl/fdn_pkg.sv
// Package: shared encodings for the input flush stage.
// Assumes binary32 layout: sign at the top, then exponent, then fraction.
package fdn_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int FLAG_W = 7;

    // Positions in the sticky flag word.
    localparam int FLG_INVALID = 0;
    localparam int FLG_DIVZERO = 2;
    localparam int FLG_OVERFLW = 3;
    localparam int FLG_UNDRFLW = 4;
    localparam int FLG_INEXACT = 5;
    localparam int FLG_IN_SUB  = 6;

    // Operation class presented with each operand pair.
    typedef enum logic [1:0] {
        CLS_DYADIC  = 2'd0,
        CLS_MONADIC = 2'd1,
        CLS_SIGNOP  = 2'd2,
        CLS_SPARE   = 2'd3
    } op_class_e;

endpackage

// File: rtl/fdn_operand_gate.sv
// Module: fdn_operand_gate
// Purpose: detect a subnormal operand and, when enabled, replace it with
// a zero of the same sign. Purely combinational.
// Assumes: operand is {sign, exponent[EXP_W], fraction[FRAC_W]}.
module fdn_operand_gate #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              check_en_i,
    output logic [DATA_W-1:0] opnd_o,
    output logic              flushed_o
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              is_sub;

    // Split the operand into its fields.
    always_comb begin
        exp_f  = opnd_i[DATA_W-2 -: EXP_W];
        frac_f = opnd_i[FRAC_W-1:0];
    end

    // Subnormal: zero exponent with a non-zero fraction.
    always_comb begin
        is_sub = (exp_f == '0) && (frac_f != '0);
    end

    // Keep only the sign bit when flushing; otherwise pass through.
    always_comb begin
        flushed_o = check_en_i && is_sub;
        if (flushed_o) begin
            opnd_o = {opnd_i[DATA_W-1], {(DATA_W-1){1'b0}}};
        end else begin
            opnd_o = opnd_i;
        end
    end

endmodule

// File: rtl/fdn_flag_acc.sv
// Module: fdn_flag_acc
// Purpose: sticky exception flag word. New events OR in every cycle; a
// synchronous clear empties it, but events in the clearing cycle survive.
// Assumes: synchronous active-low reset.
module fdn_flag_acc #(
    parameter int FLAG_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_i,
    input  logic              clr_i,
    output logic [FLAG_W-1:0] flags_o
);

    logic [FLAG_W-1:0] kept;

    // Prior contents survive unless a clear is requested.
    always_comb begin
        kept = clr_i ? '0 : flags_o;
    end

    // Register the accumulated word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else begin
            flags_o <= kept | set_i;
        end
    end

endmodule

// File: rtl/fdn_flush_stage.sv
// Module: fdn_flush_stage (top)
// Purpose: input conditioning ahead of a binary32 datapath. Flushes
// subnormal operands to signed zero under flush-inputs mode, per the
// operation class, and records an input-subnormal event in sticky flags.
// Assumes: synchronous active-low reset; one cycle latency; outputs hold
// when no valid operation is presented.
module fdn_flush_stage
    import fdn_pkg::*;
#(
    parameter int N_OPND = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic [1:0]  op_class,
    input  logic        ftz_in,
    input  logic        valid_in,
    input  logic        flag_clr,
    output logic [31:0] out_a,
    output logic [31:0] out_b,
    output logic        valid_out,
    output logic [6:0]  flags
);

    localparam int DATA_W = 1 + EXP_W + FRAC_W;

    op_class_e          cls;
    logic [N_OPND-1:0]  chk_en;
    logic [N_OPND-1:0]  hit;
    logic [DATA_W-1:0]  opnd_in  [N_OPND];
    logic [DATA_W-1:0]  opnd_out [N_OPND];
    logic               any_hit;
    logic [FLAG_W-1:0]  flag_set;

    // Decode which operand slots the operation consumes.
    always_comb begin
        cls    = op_class_e'(op_class);
        chk_en = '0;
        if (valid_in && ftz_in) begin
            unique case (cls)
                CLS_DYADIC:  chk_en = '1;
                CLS_MONADIC: chk_en[0] = 1'b1;
                default:     chk_en = '0;
            endcase
        end
    end

    // Gather operands into an indexed array.
    always_comb begin
        opnd_in[0] = op_a;
        opnd_in[1] = op_b;
    end

    // One detector/flusher per operand slot.
    for (genvar g = 0; g < N_OPND; g++) begin : g_gate
        fdn_operand_gate #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_gate (
            .opnd_i     (opnd_in[g]),
            .check_en_i (chk_en[g]),
            .opnd_o     (opnd_out[g]),
            .flushed_o  (hit[g])
        );
    end

    // Build the flag event vector: only the input-subnormal position.
    always_comb begin
        any_hit  = |hit;
        flag_set = '0;
        flag_set[FLG_IN_SUB] = any_hit;
    end

    fdn_flag_acc #(
        .FLAG_W (FLAG_W)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set),
        .clr_i   (flag_clr),
        .flags_o (flags)
    );

    // Capture conditioned operands on valid cycles; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a <= '0;
            out_b <= '0;
        end else if (valid_in) begin
            out_a <= opnd_out[0];
            out_b <= opnd_out[1];
        end
    end

    // Valid pipeline bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
        end else begin
            valid_out <= valid_in;
        end
    end

    // Marks cycles whose previous cycle was out of reset, so $past is safe.
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (valid_out == $past(valid_in)));

    a_r3_pass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(valid_in) && !$past(ftz_in)) |->
        (out_a == $past(op_a) && out_b == $past(op_b)));

    a_r6_signop_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(valid_in) && $past(op_class[1])) |->
        (out_a == $past(op_a) && out_b == $past(op_b)));

    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(flags[FLG_IN_SUB]) && !$past(flag_clr)) |->
        flags[FLG_IN_SUB]);

    a_r4_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(flags[FLG_IN_SUB])) |->
        $past(valid_in && ftz_in && !op_class[1]));

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(valid_in)) |-> ($stable(out_a) && $stable(out_b)));

endmodule

// File: tb/sim_fdn_flush_stage.sv
module sim_fdn_flush_stage;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] op_a, op_b;
    logic [1:0]  op_class;
    logic        ftz_in, valid_in, flag_clr;
    logic [31:0] out_a, out_b;
    logic        valid_out;
    logic [6:0]  flags;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // expected state
    logic [31:0] e_a, e_b;
    logic        e_v;
    logic [6:0]  e_f;

    always #4 clk = ~clk;

    fdn_flush_stage u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .op_class(op_class), .ftz_in(ftz_in), .valid_in(valid_in),
        .flag_clr(flag_clr), .out_a(out_a), .out_b(out_b),
        .valid_out(valid_out), .flags(flags)
    );

    function automatic bit is_sub(input logic [31:0] x);
        return (x[30:23] == 8'h00) && (x[22:0] != 23'h0);
    endfunction

    function automatic bit use_slot(input int slot, input logic [1:0] c);
        if (c == 2'd0) return 1'b1;
        if (c == 2'd1) return slot == 0;
        return 1'b0;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (out_a !== e_a || out_b !== e_b || valid_out !== e_v || flags !== e_f) begin
            errors++;
            $display("FAIL %s: got a=%h b=%h v=%b f=%h expected a=%h b=%h v=%b f=%h",
                     tag, out_a, out_b, valid_out, flags, e_a, e_b, e_v, e_f);
        end
    endtask

    // Drive one cycle, update the model, check after the edge.
    task automatic step(input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] c, input logic ftz,
                        input logic vld, input logic clr, input string tag);
        bit fa, fb;
        @(negedge clk);
        op_a = a; op_b = b; op_class = c; ftz_in = ftz;
        valid_in = vld; flag_clr = clr;
        fa = vld && ftz && use_slot(0, c) && is_sub(a);
        fb = vld && ftz && use_slot(1, c) && is_sub(b);
        if (vld) begin
            e_a = fa ? (a & 32'h8000_0000) : a;
            e_b = fb ? (b & 32'h8000_0000) : b;
        end
        e_v = vld;
        e_f = (clr ? 7'h00 : e_f) | ((fa || fb) ? 7'h40 : 7'h00);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    function automatic logic [31:0] pick_val();
        logic [31:0] s;
        s = {$urandom_range(1, 0), 31'h0};
        case ($urandom_range(5, 0))
            0: return s | {9'h0, 23'($urandom_range(32'h7FFFFF, 1))};
            1: return s;
            2: return s | 32'h7F80_0000;
            3: return s | 32'h7F80_0000 | {9'h0, 23'($urandom_range(32'h7FFFFF, 1))};
            4: return s | {1'b0, 8'($urandom_range(254, 1)), 23'($urandom)};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; op_a = '0; op_b = '0; op_class = '0;
        ftz_in = 0; valid_in = 0; flag_clr = 0;
        e_a = '0; e_b = '0; e_v = 0; e_f = '0;
        repeat (3) @(posedge clk);
        #1;
        compare("R9 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        step(32'h0000_0001, 32'h3F80_0000, 2'd0, 1, 1, 0, "R1 smallest subnormal a");
        step(32'h3F80_0000, 32'h807F_FFFF, 2'd0, 1, 1, 1, "R2 negative largest subnormal b, clear+set R5");
        step(32'h8012_3456, 32'h0040_0000, 2'd0, 1, 1, 1, "R7 both flushed independently");
        step(32'h0000_0000, 32'h8000_0000, 2'd0, 1, 1, 1, "R8 signed zeros untouched");
        step(32'h0080_0000, 32'h7F80_0000, 2'd0, 1, 1, 0, "R8 smallest normal and inf");
        step(32'h7FC0_0001, 32'hFF80_0001, 2'd0, 1, 1, 0, "R8 NaNs untouched");
        step(32'h0000_0005, 32'h8000_0007, 2'd0, 0, 1, 0, "R3 ftz off passes subnormals");
        step(32'h3000_0000, 32'h0000_0009, 2'd1, 1, 1, 0, "R7 one-operand leaves b");
        step(32'h8000_0003, 32'h0000_0009, 2'd2, 1, 1, 0, "R6 sign-only bypass");
        step(32'h7F80_0001, 32'h0000_0002, 2'd3, 1, 1, 0, "R6 spare class bypass");
        step(32'h0000_0011, 32'h0000_0022, 2'd0, 1, 0, 0, "R10 idle cycle no capture");
        step(32'h8000_0011, 32'h4000_0000, 2'd1, 1, 1, 0, "R4 flag bit 6 only");
        step(32'h4000_0000, 32'h4000_0000, 2'd0, 1, 1, 0, "R5 sticky survives normal traffic");
        step(32'h4000_0000, 32'h4000_0000, 2'd0, 1, 0, 1, "R5 clear without event");

        for (int i = 0; i < 3000; i++) begin
            step(pick_val(), pick_val(), 2'($urandom_range(3, 0)),
                 1'($urandom_range(3, 0) != 0), 1'($urandom_range(4, 0) != 0),
                 1'($urandom_range(15, 0) == 0), "R1 random traffic");
        end

        @(negedge clk);
        rst_n = 1'b0;
        e_a = '0; e_b = '0; e_v = 0; e_f = '0;
        @(posedge clk);
        #1;
        compare("R9 mid-run reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule